// File: doc/BRIEF.md
# Signed Multiply/Divide Coprocessor

This block is a small arithmetic engine that sits on a byte-wide register bus. It forms the signed 32-bit product of two signed 16-bit operands with no wait. It also divides a signed 32-bit dividend by a signed 16-bit divisor, which gives a 32-bit quotient and a 16-bit remainder. The division is a shift-subtract loop of 32 clock cycles that works on magnitudes, and the signs are applied in the last step.

Software sees three registers: a status/control register, a pointer register and a data port. Every read or write of the data port moves one byte of the operand/result window at the pointer address, and the pointer then steps by one. A program can therefore load every operand byte, or fetch every result byte, with a run of back-to-back data accesses after a single pointer write. A division starts when software writes a one to the start bit. Software then polls the end-of-division flag before it reads the quotient and remainder.

Top module: `arith_coproc`

## Requirements
- R1: The window holds the signed product of operand A and operand B at bytes 4..7, most significant byte first. The product can be read in the cycle right after the write of the last operand byte.
- R2: After an accepted start with a nonzero divisor, the status register reads 0x01 (busy, end-of-division clear) for 32 cycles. It reads 0x02 from the cycle after the 32nd step.
- R3: After reset the status register reads 0x02 and the pointer reads 0x00.
- R4: Each data-port read or write moves the pointer up by one, wrapping modulo 2^PTR_W. Writing the pointer register sets it, and reading it returns it zero-extended.
- R5: Window map, each field most significant byte first: A at 0-1, B at 2-3, dividend at 8-11, divisor at 12-13, quotient at 14-17, remainder at 18-19. Addresses 20 and above read 0.
- R6: The quotient is truncated toward zero, and the remainder has the sign of the dividend. The case -2^31 / -1 gives quotient 0x80000000.
- R7: A start clears end-of-division and divide-by-zero. The operands are captured when the start is taken, so writing them during the run does not change the result.
- R8: A start with a zero divisor sets divide-by-zero and end-of-division at once (status 0x06), and forces the quotient and remainder to zero.
- R9: A start write made while a division is running has no effect, and the running division ends at its original time.
- R10: Writes to the product, quotient and remainder bytes have no effect.
- R11: Status layout: bit 0 busy, bit 1 end-of-division, bit 2 divide-by-zero, bits 7..3 read 0. Of a write, only bit 0 (start) acts.
- R12: regSel encoding: 0 status, 1 pointer, 2 data, 3 unused. Code 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a data read moves the pointer) |
| regSel | input | 2 | Register select: 0 status, 1 pointer, 2 data |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte of the selected register |

## Verification
Two things can land in the same cycle: a start write and a division that is already running. Software can also write operand bytes while the loop is still consuming its captured copy. The bench issues a second start two cycles into a division, then overwrites a dividend byte. It checks that the status flips to 0x02 exactly 32 cycles after the first start, and that the quotient and remainder are those of the original operands. A further case puts a data access next to the pointer wrap, to check that the increment and the window decode agree at the boundary.

// File: rtl/arith_coproc_pkg.sv
package arith_coproc_pkg;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_PTR  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrByte;   // data-port write at the pointer address
    logic loadDiv;  // capture operands, start iterations
    logic zeroDiv;  // zero divisor: force results to zero
    logic step;     // one shift-subtract iteration
    logic last;     // final iteration: commit signed results
  } ctrlStrobes_t;

endpackage

// File: rtl/arith_coproc_ctrl.sv
module arith_coproc_ctrl
  import arith_coproc_pkg::*;
#(
  parameter int PTR_W = 5,
  parameter int ITER  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       regSel,
  input  logic [PTR_W-1:0] wrLow,
  input  logic             dvsZero,
  output ctrlStrobes_t     stb,
  output logic [PTR_W-1:0] ptrQ,
  output logic [7:0]       statusByte
);

  localparam int CNT_W = $clog2(ITER);

  logic             busyQ, eodQ, dbzQ;
  logic [CNT_W-1:0] iterCnt;
  logic             startReq, dataAcc, lastIter;

  assign startReq = wrEn && (regSel == SEL_STAT) && wrLow[0] && !busyQ;
  assign dataAcc  = (wrEn || rdEn) && (regSel == SEL_DATA);
  assign lastIter = busyQ && (iterCnt == CNT_W'(ITER - 1));

  always_comb begin
    stb.wrByte  = wrEn && (regSel == SEL_DATA);
    stb.loadDiv = startReq && !dvsZero;
    stb.zeroDiv = startReq && dvsZero;
    stb.step    = busyQ;
    stb.last    = lastIter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (wrEn && (regSel == SEL_PTR)) begin
      ptrQ <= wrLow;
    end else if (dataAcc) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      eodQ    <= 1'b1;
      dbzQ    <= 1'b0;
      iterCnt <= '0;
    end else if (stb.loadDiv) begin
      busyQ   <= 1'b1;
      eodQ    <= 1'b0;
      dbzQ    <= 1'b0;
      iterCnt <= '0;
    end else if (stb.zeroDiv) begin
      eodQ <= 1'b1;
      dbzQ <= 1'b1;
    end else if (lastIter) begin
      busyQ <= 1'b0;
      eodQ  <= 1'b1;
    end else if (busyQ) begin
      iterCnt <= iterCnt + 1'b1;
    end
  end

  assign statusByte = {5'b0, dbzQ, eodQ, busyQ};

endmodule

// File: rtl/arith_coproc_dp.sv
module arith_coproc_dp
  import arith_coproc_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     stb,
  input  logic [PTR_W-1:0] addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdByte,
  output logic             dvsZero
);

  localparam int DW     = 2 * OPW;
  localparam int OPB    = OPW / 8;
  localparam int BASE_A = 0;
  localparam int BASE_B = OPB;
  localparam int BASE_D = 4 * OPB;
  localparam int BASE_V = 6 * OPB;
  localparam int WIN_W  = 10 * OPW;
  localparam int NBYTES = WIN_W / 8;

  logic [OPW-1:0] opA, opB, dvs, rem;
  logic [DW-1:0]  dvd, quot;
  logic signed [DW-1:0] prod;

  // iteration state
  logic [DW-1:0]  nReg;
  logic [OPW-1:0] pReg, dMag;
  logic           negQ, negR;

  logic [OPW:0]   shifted, nextPw;
  logic [DW-1:0]  nextN;
  logic           fits;
  logic [WIN_W-1:0] window;
  int             addrI;

  assign prod    = $signed(opA) * $signed(opB);
  assign dvsZero = (dvs == '0);
  assign addrI   = int'(addr);

  always_comb begin
    shifted = {pReg, nReg[DW-1]};
    fits    = shifted >= {1'b0, dMag};
    nextPw  = fits ? (shifted - {1'b0, dMag}) : shifted;
    nextN   = {nReg[DW-2:0], fits};
  end

  // operand bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA <= '0;
      opB <= '0;
      dvd <= '0;
      dvs <= '0;
    end else if (stb.wrByte) begin
      if (addrI < BASE_B)
        opA[OPW-1-8*(addrI-BASE_A) -: 8] <= wrData;
      else if (addrI < 2 * OPB)
        opB[OPW-1-8*(addrI-BASE_B) -: 8] <= wrData;
      else if (addrI >= BASE_D && addrI < BASE_V)
        dvd[DW-1-8*(addrI-BASE_D) -: 8] <= wrData;
      else if (addrI >= BASE_V && addrI < BASE_V + OPB)
        dvs[OPW-1-8*(addrI-BASE_V) -: 8] <= wrData;
    end
  end

  // division loop on magnitudes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg <= '0;
      pReg <= '0;
      dMag <= '0;
      negQ <= 1'b0;
      negR <= 1'b0;
      quot <= '0;
      rem  <= '0;
    end else if (stb.loadDiv) begin
      nReg <= dvd[DW-1] ? (~dvd + 1'b1) : dvd;
      dMag <= dvs[OPW-1] ? (~dvs + 1'b1) : dvs;
      pReg <= '0;
      negQ <= dvd[DW-1] ^ dvs[OPW-1];
      negR <= dvd[DW-1];
    end else if (stb.zeroDiv) begin
      quot <= '0;
      rem  <= '0;
    end else if (stb.step) begin
      nReg <= nextN;
      pReg <= OPW'(nextPw);
      if (stb.last) begin
        quot <= negQ ? (~nextN + 1'b1) : nextN;
        rem  <= negR ? (~OPW'(nextPw) + 1'b1) : OPW'(nextPw);
      end
    end
  end

  assign window = {opA, opB, prod, dvd, dvs, quot, rem};

  always_comb begin
    rdByte = 8'h00;
    if (addrI < NBYTES)
      rdByte = window[WIN_W-1-8*addrI -: 8];
  end

endmodule

// File: rtl/arith_coproc.sv
module arith_coproc
  import arith_coproc_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int PTR_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);

  ctrlStrobes_t     stb;
  logic [PTR_W-1:0] ptrQ;
  logic [7:0]       statusByte, dpByte;
  logic             dvsZero;
  logic             busyS, eodS, dbzS;

  arith_coproc_ctrl #(.PTR_W(PTR_W), .ITER(2 * OPW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrLow(wrData[PTR_W-1:0]), .dvsZero(dvsZero), .stb(stb),
    .ptrQ(ptrQ), .statusByte(statusByte)
  );

  arith_coproc_dp #(.OPW(OPW), .PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(ptrQ), .wrData(wrData),
    .rdByte(dpByte), .dvsZero(dvsZero)
  );

  assign busyS = statusByte[0];
  assign eodS  = statusByte[1];
  assign dbzS  = statusByte[2];

  always_comb begin
    case (regSel)
      SEL_STAT: rdData = statusByte;
      SEL_PTR:  rdData = 8'(ptrQ);
      SEL_DATA: rdData = dpByte;
      default:  rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/arith_coproc_chk.sv
module arith_coproc_chk #(
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [1:0]       regSel,
  input logic             startBit,
  input logic             busy,
  input logic             eod,
  input logic             dbz,
  input logic [PTR_W-1:0] ptr
);

  logic [6:0] runLen;
  logic       startOk;

  assign startOk = wrEn && (regSel == 2'd0) && startBit && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        runLen <= '0;
    else if (startOk) runLen <= '0;
    else if (busy)    runLen <= runLen + 1'b1;
  end

  // R2: end-of-division rises exactly 32 steps after the accepted start
  a_r2_div_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eod) |-> runLen == 7'd32);

  // R9: a start written during a run keeps the run going
  a_r9_restart_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && regSel == 2'd0 && startBit && runLen < 7'd31) |=> busy);

  // R7: an accepted start clears end-of-division unless the divisor is zero
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> (!eod || dbz));

  // R8: divide-by-zero comes with end-of-division and no run
  a_r8_zero_flags: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbz) |-> (eod && !busy));

  // R4: every data access steps the pointer
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn || rdEn) && regSel == 2'd2) |=> ptr == $past(ptr) + 1'b1);

  // R11: busy and end-of-division never read together
  a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(eod && busy));

endmodule

bind arith_coproc arith_coproc_chk #(.PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
  .startBit(wrData[0]), .busy(busyS), .eod(eodS), .dbz(dbzS), .ptr(ptrQ)
);

// File: tb/tb_arith_coproc.sv
module tb_arith_coproc;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  logic [7:0] expV[$];
  string      expTag[$];

  arith_coproc dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    #(CLK_PERIOD / 4);
    if (rdEn) begin
      checks++;
      if (expV.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: got %02h expected none", rdData);
      end else begin
        automatic logic [7:0] v = expV.pop_front();
        automatic string t = expTag.pop_front();
        if (rdData !== v) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", t, rdData, v);
        end
      end
    end
  end

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = val;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expV.push_back(exp); expTag.push_back(tag);
    rdEn = 1'b1; regSel = sel;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic doMul(input logic signed [15:0] a, input logic signed [15:0] b);
    logic signed [31:0] p;
    p = 32'(longint'(a) * longint'(b));
    wrReg(2'd1, 8'd0);
    wrReg(2'd2, a[15:8]); wrReg(2'd2, a[7:0]);
    wrReg(2'd2, b[15:8]); wrReg(2'd2, b[7:0]);
    for (int i = 0; i < 4; i++) rdReg(2'd2, p[31-8*i -: 8], "R1 product");
    rdReg(2'd1, 8'd8, "R4 pointer after 8 data accesses");
  endtask

  task automatic loadDiv(input logic signed [31:0] a, input logic signed [15:0] b);
    wrReg(2'd1, 8'd8);
    for (int i = 0; i < 4; i++) wrReg(2'd2, a[31-8*i -: 8]);
    wrReg(2'd2, b[15:8]); wrReg(2'd2, b[7:0]);
  endtask

  task automatic readDivResult(input logic signed [31:0] a, input logic signed [15:0] b);
    logic [31:0] q;
    logic [15:0] r;
    if (b == 0) begin
      q = '0; r = '0;
    end else begin
      q = 32'(longint'(a) / longint'(b));
      r = 16'(longint'(a) % longint'(b));
    end
    wrReg(2'd1, 8'd14);
    for (int i = 0; i < 4; i++) rdReg(2'd2, q[31-8*i -: 8], "R6 quotient");
    for (int i = 0; i < 2; i++) rdReg(2'd2, r[15-8*i -: 8], "R6 remainder");
  endtask

  task automatic doDiv(input logic signed [31:0] a, input logic signed [15:0] b);
    loadDiv(a, b);
    wrReg(2'd0, 8'h01);
    if (b == 0) begin
      rdReg(2'd0, 8'h06, "R8 zero divisor status");
    end else begin
      rdReg(2'd0, 8'h01, "R7 start clears end flag");
      repeat (30) @(posedge clk);
      rdReg(2'd0, 8'h01, "R2 still busy at step 31");
      rdReg(2'd0, 8'h02, "R2 done after 32 steps");
    end
    readDivResult(a, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R3 reset state
    rdReg(2'd0, 8'h02, "R3 status at reset");
    rdReg(2'd1, 8'h00, "R3 pointer at reset");

    // R1 products
    doMul(16'sd3, 16'sd4);
    doMul(-16'sd7, 16'sd300);
    doMul(-16'sd32768, -16'sd32768);
    doMul(16'sd32767, -16'sd1);

    // R5 operand read-back and R10 product write ignored
    wrReg(2'd1, 8'd0);
    rdReg(2'd2, 8'h7F, "R5 operand A msb");
    wrReg(2'd1, 8'd4);
    wrReg(2'd2, 8'h55);
    wrReg(2'd1, 8'd4);
    rdReg(2'd2, 8'hFF, "R10 product byte unchanged");

    // R6 divisions
    doDiv(32'sd1000, 16'sd7);
    doDiv(-32'sd1000, 16'sd7);
    doDiv(32'sd1000, -16'sd7);
    doDiv(-32'sd2147483648, -16'sd1);
    doDiv(32'sd2147483647, 16'sd32767);
    doDiv(-32'sd5, -16'sd32768);

    // R8 zero divisor, then R7 a nonzero start clears it
    doDiv(32'sd1234, 16'sd0);
    doDiv(32'sd99, 16'sd10);

    // R10 quotient write ignored
    wrReg(2'd1, 8'd17);
    wrReg(2'd2, 8'hAA);
    wrReg(2'd1, 8'd17);
    rdReg(2'd2, 8'h09, "R10 quotient byte unchanged");

    // R9 restart ignored, R7 operands captured at start
    loadDiv(32'sd1000, 16'sd7);
    wrReg(2'd0, 8'h01);                 // start at edge s
    rdReg(2'd0, 8'h01, "R9 busy");      // s+1
    wrReg(2'd0, 8'h01);                 // s+2, ignored
    wrReg(2'd1, 8'd8);                  // s+3
    wrReg(2'd2, 8'hFF);                 // s+4, dividend changed mid-run
    repeat (27) @(posedge clk);         // s+31
    rdReg(2'd0, 8'h01, "R9 still busy at step 31");
    rdReg(2'd0, 8'h02, "R9 ends at original time");
    readDivResult(32'sd1000, 16'sd7);

    // R4 wrap and R5 unmapped byte
    wrReg(2'd1, 8'd31);
    rdReg(2'd2, 8'h00, "R5 unmapped address reads zero");
    rdReg(2'd1, 8'h00, "R4 pointer wraps");

    // R12 unused select, R11 only the start bit acts
    rdReg(2'd3, 8'h00, "R12 unused select reads zero");
    wrReg(2'd3, 8'hFF);
    rdReg(2'd1, 8'h00, "R12 unused write leaves pointer");
    wrReg(2'd0, 8'hFE);
    rdReg(2'd0, 8'h02, "R11 status bits not writable");

    @(negedge clk); @(negedge clk);
    if (expV.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", expV.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule